// File: doc/BRIEF.md
# Capture-Compare Timer with PWM

A 16-bit up-counter that advances on a prescaled tick. The tick comes either from the system clock or from rising edges of an external clock pin, and either source is divided by a power of two. A set of capture channels records the count when their pins show a chosen edge. Two compare registers act on a single output pin. In plain mode each compare match drives the pin to a programmed level. In PWM mode the first compare sets the period and the second sets the duty cycle.

Overflow, each compare match and each capture set their own sticky pending flag. A single interrupt line is the OR of every pending flag whose enable bit is set. Software clears a flag by writing a one to it. All state is reached through a flat word-addressed register bus: writes take effect on the clock edge, and reads are combinational.

Register map (4-bit word address, 16-bit data):
- CTRL at 0: bit 0 run, bit 1 external source, bits 4:2 the prescale exponent n, bit 5 PWM mode.
- CMPCFG at 1: bit k is the pin level for compare k, where 1 means high.
- CAPCFG at 2: bit i is the edge for capture i, where 1 means rising and 0 means falling.
- STATUS at 3 and IE at 7 share one layout: bit 0 overflow, bit 1 compare 0, bit 2 compare 1, bit 3+i capture i.
- COUNT at 4.
- CMP0 at 5 and CMP1 at 6.
- CAP i at 8+i.

Top module: `cc_timer`

## Requirements
- R1: The 16-bit count rises by one on each tick only while CTRL bit 0 is set. A bus write to COUNT (address 4) loads the written value, and that load wins over a tick in the same cycle.
- R2: With CTRL bit 1 clear, the system clock drives the count, and a tick occurs once every 2^n clock cycles, where n is CTRL bits 4:2.
- R3: With CTRL bit 1 set, the count source is rising edges of ext_clk_i, and a tick occurs once every 2^n of those edges.
- R4: A tick at count 0xFFFF wraps the count to 0 and sets STATUS bit 0, except when a PWM restart happens on that tick.
- R5: Capture channel i latches the count into CAP i (address 8+i) and sets STATUS bit 3+i on the edge chosen by CAPCFG bit i (1 selects rising, 0 selects falling). The other edge has no effect. The pin passes through two synchronizing flops first.
- R6: With CTRL bit 5 clear, a tick on which the count equals CMPk (address 5+k) drives cmp_o to the level in CMPCFG bit k and sets STATUS bit 1+k. If both compares match on the same tick, compare 1 sets the level.
- R7: With CTRL bit 5 set, a match on CMP0 sets cmp_o and makes the next count 0, so the period is CMP0+1 ticks.
- R8: With CTRL bit 5 set, a match on CMP1 clears cmp_o. When both compares match on the same tick the clear wins, so CMP1 equal to CMP0 holds cmp_o low.
- R9: irq_o is high exactly when some STATUS bit and the IE bit at the same position (address 7) are both set.
- R10: STATUS bits stay set until software writes 1 to them. Writing 0 has no effect. An event in the same cycle as the clear of its own bit leaves that bit set.
- R11: After reset all registers are zero, and cmp_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| ext_clk_i | input | 1 | External count clock |
| cap_i | input | N_CAP | Capture pins |
| cmp_o | output | 1 | Compare / PWM output |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two events can land in the same cycle: a capture event setting its STATUS bit, and a software write of 1 that clears that same bit. The bench counts synchronizer stages to find the edge on which capture channel 1 registers a falling edge. It places a STATUS write of 1 to bit 4 on exactly that edge, and then expects bit 4 to read back as set. A second pairing puts both compare matches on one PWM tick, by making CMP1 equal to CMP0. The bench then expects cmp_o to stay low across many periods.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
package cct_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_CMPCFG   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CAPCFG   = 4'd2;
  localparam logic [ADDR_W-1:0] A_STATUS   = 4'd3;
  localparam logic [ADDR_W-1:0] A_COUNT    = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP0     = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMP1     = 4'd6;
  localparam logic [ADDR_W-1:0] A_IE       = 4'd7;
  localparam int unsigned       A_CAP_BASE = 8;
  // CTRL field positions
  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_EXT  = 1;
  localparam int unsigned C_SHL  = 2;
  localparam int unsigned C_PWM  = 5;
  localparam int unsigned CTRL_W = 6;
endpackage

// File: rtl/cct_prescaler.sv
`timescale 1ns/1ps
module cct_prescaler #(
  parameter int unsigned SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               ext_sel_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               ext_clk_i,
  output logic               tick_o
);
  localparam int unsigned DIV_W = (1 << SHIFT_W) - 1;

  logic [1:0]       ext_sync_q;
  logic             ext_prev_q;
  logic [DIV_W-1:0] div_q, mask;
  logic             src_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_sync_q <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      ext_sync_q <= {ext_sync_q[0], ext_clk_i};
      ext_prev_q <= ext_sync_q[1];
    end
  end

  assign src_pulse = ext_sel_i ? (ext_sync_q[1] & ~ext_prev_q) : 1'b1;
  assign mask      = ~({DIV_W{1'b1}} << shift_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (!run_i)    div_q <= '0;
    else if (src_pulse) div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i & src_pulse & ((div_q & mask) == mask);

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> run_i); // R1
  AST_DIV_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && shift_i != '0 && $stable(shift_i)) |=> !tick_o); // R2
endmodule

// File: rtl/cct_capture.sv
`timescale 1ns/1ps
module cct_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             rise_sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             evt_o,
  output logic [CNT_W-1:0] cap_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= sync_q[1];
    end
  end

  assign evt_o = rise_sel_i ? (sync_q[1] & ~prev_q) : (~sync_q[1] & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_o <= '0;
    else if (evt_o) cap_o <= cnt_i;
  end

  AST_CAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> cap_o == $past(cnt_i)); // R5
  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_o |=> $stable(cap_o)); // R5
endmodule

// File: rtl/cct_cmp_out.sv
`timescale 1ns/1ps
module cct_cmp_out #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pwm_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp0_i,
  input  logic [CNT_W-1:0] cmp1_i,
  input  logic [1:0]       act_i,
  output logic [1:0]       match_o,
  output logic             restart_o,
  output logic             out_o
);
  assign match_o[0] = tick_i && (cnt_i == cmp0_i);
  assign match_o[1] = tick_i && (cnt_i == cmp1_i);
  assign restart_o  = pwm_i && match_o[0];

  // compare 1 has priority in both modes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         out_o <= 1'b0;
    else if (match_o[1]) out_o <= pwm_i ? 1'b0 : act_i[1];
    else if (match_o[0]) out_o <= pwm_i ? 1'b1 : act_i[0];
  end

  AST_PWM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && match_o[0] && !match_o[1]) |=> out_o); // R7
  AST_PWM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && match_o[1]) |=> !out_o); // R8
  AST_CMP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_i && match_o[1]) |=> out_o == $past(act_i[1])); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(out_o)); // R6
endmodule

// File: rtl/cc_timer.sv
`timescale 1ns/1ps
module cc_timer
  import cct_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned N_CAP   = 2,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              ext_clk_i,
  input  logic [N_CAP-1:0]  cap_i,
  output logic              cmp_o,
  output logic              irq_o
);
  localparam int unsigned ST_W = 3 + N_CAP;

  logic [CTRL_W-1:0] ctrl_q;
  logic [1:0]        cmpcfg_q;
  logic [N_CAP-1:0]  capcfg_q;
  logic [ST_W-1:0]   pend_q, ie_q, pend_set, pend_clr;
  logic [CNT_W-1:0]  cnt_q, cmp0_q, cmp1_q;
  logic [CNT_W-1:0]  cap_val [N_CAP];
  logic [N_CAP-1:0]  cap_evt;
  logic [1:0]        match;
  logic              tick, restart, ovf, cnt_load;

  function automatic logic wr(input logic [ADDR_W-1:0] a);
    return bus_we_i && (bus_addr_i == a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      cmpcfg_q <= '0;
      capcfg_q <= '0;
      ie_q     <= '0;
      cmp0_q   <= '0;
      cmp1_q   <= '0;
    end else begin
      if (wr(A_CTRL))   ctrl_q   <= bus_wdata_i[CTRL_W-1:0];
      if (wr(A_CMPCFG)) cmpcfg_q <= bus_wdata_i[1:0];
      if (wr(A_CAPCFG)) capcfg_q <= bus_wdata_i[N_CAP-1:0];
      if (wr(A_IE))     ie_q     <= bus_wdata_i[ST_W-1:0];
      if (wr(A_CMP0))   cmp0_q   <= bus_wdata_i;
      if (wr(A_CMP1))   cmp1_q   <= bus_wdata_i;
    end
  end

  cct_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk_i, .rst_ni,
    .run_i     (ctrl_q[C_RUN]),
    .ext_sel_i (ctrl_q[C_EXT]),
    .shift_i   (ctrl_q[C_SHL +: SHIFT_W]),
    .ext_clk_i,
    .tick_o    (tick)
  );

  cct_cmp_out #(.CNT_W(CNT_W)) u_cmp (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .pwm_i     (ctrl_q[C_PWM]),
    .cnt_i     (cnt_q),
    .cmp0_i    (cmp0_q),
    .cmp1_i    (cmp1_q),
    .act_i     (cmpcfg_q),
    .match_o   (match),
    .restart_o (restart),
    .out_o     (cmp_o)
  );

  for (genvar g = 0; g < N_CAP; g++) begin : g_cap
    cct_capture #(.CNT_W(CNT_W)) u_cap (
      .clk_i, .rst_ni,
      .pin_i      (cap_i[g]),
      .rise_sel_i (capcfg_q[g]),
      .cnt_i      (cnt_q),
      .evt_o      (cap_evt[g]),
      .cap_o      (cap_val[g])
    );
  end

  assign cnt_load = wr(A_COUNT);
  assign ovf      = tick && !restart && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_load) cnt_q <= bus_wdata_i;
    else if (tick)     cnt_q <= restart ? '0 : cnt_q + 1'b1;
  end

  assign pend_set = {cap_evt, match, ovf};
  assign pend_clr = wr(A_STATUS) ? bus_wdata_i[ST_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~pend_clr) | pend_set;
  end

  assign irq_o = |(pend_q & ie_q);

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL:   bus_rdata_o = CNT_W'(ctrl_q);
      A_CMPCFG: bus_rdata_o = CNT_W'(cmpcfg_q);
      A_CAPCFG: bus_rdata_o = CNT_W'(capcfg_q);
      A_STATUS: bus_rdata_o = CNT_W'(pend_q);
      A_COUNT:  bus_rdata_o = cnt_q;
      A_CMP0:   bus_rdata_o = cmp0_q;
      A_CMP1:   bus_rdata_o = cmp1_q;
      A_IE:     bus_rdata_o = CNT_W'(ie_q);
      default: begin
        for (int i = 0; i < N_CAP; i++)
          if (bus_addr_i == ADDR_W'(A_CAP_BASE + i)) bus_rdata_o = cap_val[i];
      end
    endcase
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !cnt_load) |=> $stable(cnt_q)); // R1
  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_load && !ctrl_q[C_PWM] && cnt_q == {CNT_W{1'b1}}) |=> (pend_q[0] && cnt_q == '0)); // R4
  AST_PWM_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !cnt_load) |=> cnt_q == '0); // R7
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_q) & ~$past(pend_clr)) & ~pend_q) == '0)); // R10
  AST_IRQ_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr(A_STATUS) && pend_set == '0 && (bus_wdata_i[ST_W-1:0] & pend_q & ie_q) == (pend_q & ie_q)) |=> !irq_o); // R9
endmodule

// File: tb/cc_timer_tb_top.sv
`timescale 1ns/1ps
module cc_timer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        ext_clk = 1'b0;
  logic [1:0]  cap = '0;
  logic        cmp, irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cc_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_clk_i(ext_clk),
    .cap_i(cap), .cmp_o(cmp), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [15:0] ctrl(input bit run, input bit ext, input int n, input bit pwm);
    return {10'd0, pwm, n[2:0], ext, run};
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    rd(4, v); check("R11 count", v, 0);
    rd(3, v); check("R11 status", v, 0);
    check("R11 cmp_o", cmp, 0);
    check("R11 irq_o", irq, 0);
  endtask

  task automatic t_prescale();
    logic [15:0] a, b;
    wr(4, 0); wr(0, ctrl(1, 0, 2, 0));
    repeat (3) @(negedge clk);
    rd(4, a); repeat (40) @(negedge clk); rd(4, b);
    check("R2 div4 ticks in 40 cycles", 16'(b - a), 10);
    wr(0, ctrl(1, 0, 0, 0));
    repeat (2) @(negedge clk);
    rd(4, a); repeat (17) @(negedge clk); rd(4, b);
    check("R1 div1 ticks in 17 cycles", 16'(b - a), 17);
    wr(0, 0); rd(4, a); repeat (10) @(negedge clk); rd(4, b);
    check("R1 stopped count holds", 16'(b - a), 0);
  endtask

  task automatic t_ext();
    logic [15:0] a, b;
    wr(0, ctrl(1, 1, 0, 0));
    repeat (5) @(negedge clk); rd(4, a);
    for (int i = 0; i < 5; i++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (5) @(negedge clk); rd(4, b);
    check("R3 ext edges n=0", 16'(b - a), 5);
    wr(0, ctrl(1, 1, 1, 0)); rd(4, a);
    for (int i = 0; i < 6; i++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (5) @(negedge clk); rd(4, b);
    check("R3 ext edges n=1", 16'(b - a), 3);
    wr(0, 0);
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    wr(7, 16'h0001); wr(4, 16'hFFFE); wr(3, 16'hFFFF);
    rd(3, v); check("R4 no flag before wrap", v[0], 0);
    wr(0, ctrl(1, 0, 0, 0));
    repeat (4) @(negedge clk);
    rd(3, v); check("R4 overflow flag", v[0], 1);
    check("R9 irq on enabled overflow", irq, 1);
    wr(0, 0);
    rd(4, v); check("R4 wrapped count small", int'(v < 16'd8), 1);
    wr(3, 16'h0000);
    rd(3, v); check("R10 write 0 keeps flag", v[0], 1);
    wr(3, 16'h0001);
    rd(3, v); check("R10 write 1 clears flag", v[0], 0);
    check("R9 irq drops after clear", irq, 0);
  endtask

  task automatic t_compare();
    logic [15:0] v;
    wr(5, 10); wr(6, 20); wr(1, 16'b01); wr(4, 0); wr(3, 16'hFFFF);
    check("R6 output low before match", cmp, 0);
    wr(0, ctrl(1, 0, 0, 0));
    repeat (14) @(negedge clk);
    check("R6 compare 0 drives high", cmp, 1);
    rd(3, v); check("R6 compare 0 flag", v[2:1], 2'b01);
    repeat (12) @(negedge clk);
    check("R6 compare 1 drives low", cmp, 0);
    rd(3, v); check("R6 compare 1 flag", v[2], 1);
    wr(0, 0);
  endtask

  task automatic t_pwm(input int per, input int duty, input int exp_high, input string req);
    logic [15:0] v;
    int highs = 0, maxc = 0;
    wr(0, 0); wr(5, 16'(per)); wr(6, 16'(duty)); wr(4, 0);
    wr(0, ctrl(1, 0, 0, 1));
    repeat (25) @(negedge clk);
    wr(3, 16'hFFFF);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); rd(4, v);
      highs += int'(cmp);
      if (int'(v) > maxc) maxc = int'(v);
    end
    check({req, " high cycles per 100"}, highs, exp_high);
    check("R7 count never passes period", maxc, per);
    rd(3, v); check("R7 no overflow in PWM", v[0], 0);
    wr(0, 0);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    wr(2, 16'b01); wr(7, 16'h0008); wr(4, 16'h1234); wr(3, 16'hFFFF);
    cap[0] = 1'b1; repeat (4) @(negedge clk);
    rd(8, v); check("R5 rising capture value", v, 16'h1234);
    rd(3, v); check("R5 capture 0 flag", v[3], 1);
    check("R9 irq on capture 0", irq, 1);
    wr(3, 16'hFFFF); wr(4, 16'h5555);
    cap[0] = 1'b0; repeat (4) @(negedge clk);
    rd(8, v); check("R5 falling edge ignored on rising channel", v, 16'h1234);
    rd(3, v); check("R5 no flag on ignored edge", v[3], 0);
    wr(4, 16'h0777);
    cap[1] = 1'b1; repeat (4) @(negedge clk);
    rd(3, v); check("R5 rising ignored on falling channel", v[4], 0);
    cap[1] = 1'b0; repeat (4) @(negedge clk);
    rd(9, v); check("R5 falling capture value", v, 16'h0777);
    rd(3, v); check("R5 capture 1 flag", v[4], 1);
    check("R9 irq low when flag not enabled", irq, 0);
  endtask

  task automatic t_set_vs_clear();
    logic [15:0] v;
    cap[1] = 1'b1; repeat (4) @(negedge clk);
    cap[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = 4'd3; wdata = 16'h0010;
    @(negedge clk); we = 1'b0;
    rd(3, v); check("R10 set wins over clear same cycle", v[4], 1);
    wr(3, 16'h0010);
    rd(3, v); check("R10 plain clear", v[4], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_ext();
    t_overflow();
    t_compare();
    t_pwm(9, 3, 40, "R7");
    t_pwm(9, 9, 0, "R8");
    t_capture();
    t_set_vs_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule